// File: doc/BRIEF.md
# Real-Time Clock with Alarm

This block keeps wall time as day, hour, minute and second counters. It runs from a reference strobe that pulses once for each period of a low-frequency reference oscillator, already brought into the system clock domain. A fractional prescaler turns the strobe count for the selected reference frequency into a 512 Hz phase. That phase drives a 1 Hz advance of the time counters and a set of periodic sample events at every power of two from 2 Hz to 512 Hz.

A programmable alarm is compared against the full time, day included. Alarm hits, the 1 Hz update and each periodic rate set sticky status bits. Software clears a status bit by writing a one to it. Each status bit has an enable bit, and the single level interrupt output is the OR of the pending bits whose enable is set.

A simple register bus gives access to the block. A write is a single strobed cycle. Read data follows the address combinationally.

Top module: `rtc_core`

## Requirements
- R1: After reset every mapped register reads 0 and irq_o is low.
- R2: Control register (offset 0x10): bit 7 is the run enable and bits [6:5] select the reference frequency; both read back as written. While bit 7 is 0 the time counters do not move.
- R3: With run enabled, the seconds count advances exactly once per REF_HZ_0 reference strobes for select 00, REF_HZ_1 for 01, REF_HZ_2 for 10, and REF_HZ_0 for 11. Each REF_HZ value must be at least 512.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and increment the day count.
- R5: The day count (offset 0x20, DAY_W bits wide) wraps from its all-ones value to 0.
- R6: Periodic status bits: bit 7 sets at 2 Hz, and bits 8 to 15 set at 4, 8, 16, 32, 64, 128, 256 and 512 Hz. Rate 2^j Hz sets once every REF_HZ/2^j strobes whenever that ratio is an integer.
- R7: Status bit 4 sets on the same clock edge on which the seconds count advances.
- R8: Status bit 2 (alarm) sets once, on entering a state in which day, hour, minute and second all equal the alarm registers (offsets 0x24, 0x08, 0x0C). This happens only while run is enabled. Clearing the bit while the match persists does not set it again.
- R9: Writing 1 to a status bit (offset 0x14) clears it and writing 0 leaves it alone. When a clear and a new event for the same bit fall on the same edge, the bit ends up set.
- R10: irq_o is high exactly when some status bit and its enable bit (offset 0x18, same bit positions) are both 1. A pending bit that is not enabled does not raise irq_o.
- R11: Time register writes take effect on the next clock edge and cancel any advance on that edge. The hour/minute registers (offsets 0x00 and 0x08) hold the hour in bits [15:8] and the minute in bits [7:0], and the seconds registers (offsets 0x04 and 0x0C) hold the second in bits [5:0].
- R12: Unmapped offsets, for example 0x1C and 0x28, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per reference oscillator period |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | Write qualifier for sel_i |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt, enabled pending status |

## Verification
A status clear written by software and a hardware event that sets the same bit can land on the same clock edge. The 512 Hz bit makes this easy to provoke. With a 1024-strobe reference it sets on every second edge, so the bench holds a write-one-to-clear of bit 15 for eight consecutive cycles and reads the status register at each cycle. The bench judges the result by seeing the bit both cleared and set again within that window, which shows that clears work and that an event on the clearing edge survives. The alarm is also checked for firing exactly once within a second in which it stays matched, despite a software clear in the middle of that second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [5:0] OFS_HM   = 6'h00;
  localparam logic [5:0] OFS_SEC  = 6'h04;
  localparam logic [5:0] OFS_AHM  = 6'h08;
  localparam logic [5:0] OFS_ASEC = 6'h0C;
  localparam logic [5:0] OFS_CTRL = 6'h10;
  localparam logic [5:0] OFS_STAT = 6'h14;
  localparam logic [5:0] OFS_IEN  = 6'h18;
  localparam logic [5:0] OFS_DAY  = 6'h20;
  localparam logic [5:0] OFS_ADAY = 6'h24;

  localparam int BIT_ALARM = 2;
  localparam int BIT_SEC   = 4;
  localparam int BIT_RATE0 = 7;
  localparam logic [15:0] STAT_MASK = 16'hFF94;

  localparam int NRATE = 10;  // index 0 = 1 Hz, index j = 2^j Hz

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int REF_HZ_0 = 32768,
  parameter int REF_HZ_1 = 32000,
  parameter int REF_HZ_2 = 38400,
  parameter int NRATE    = rtc_pkg::NRATE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ref_tick_i,
  input  logic [1:0]       fsel_i,
  output logic [NRATE-1:0] rate_tick_o
);
  localparam int PH_W    = NRATE - 1;
  localparam int STEP    = 2 ** PH_W;
  localparam int LIM_MAX = (REF_HZ_0 > REF_HZ_1) ?
                           ((REF_HZ_0 > REF_HZ_2) ? REF_HZ_0 : REF_HZ_2) :
                           ((REF_HZ_1 > REF_HZ_2) ? REF_HZ_1 : REF_HZ_2);
  localparam int ACC_W   = $clog2(LIM_MAX + STEP) + 1;

  logic [ACC_W-1:0] acc_q, acc_sum, lim;
  logic [PH_W-1:0]  ph_q, ph_nxt;
  logic [NRATE-1:0] hit, tick_q;
  logic             step;

  always_comb begin
    unique case (fsel_i)
      2'b01:   lim = ACC_W'(REF_HZ_1);
      2'b10:   lim = ACC_W'(REF_HZ_2);
      default: lim = ACC_W'(REF_HZ_0);
    endcase
  end

  assign acc_sum = acc_q + ACC_W'(STEP);
  assign step    = ref_tick_i && (acc_sum >= lim);
  assign ph_nxt  = ph_q + PH_W'(1);

  // rate 2^j fires when the low PH_W-j phase bits wrap to zero
  for (genvar j = 0; j < NRATE; j++) begin : g_rate
    if (j == NRATE - 1) begin : g_top
      assign hit[j] = 1'b1;
    end else begin : g_div
      assign hit[j] = (ph_nxt[PH_W-1-j:0] == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      ph_q   <= '0;
      tick_q <= '0;
    end else if (!en_i) begin
      acc_q  <= '0;
      ph_q   <= '0;
      tick_q <= '0;
    end else begin
      tick_q <= step ? hit : '0;
      if (ref_tick_i) acc_q <= step ? (acc_sum - lim) : acc_sum;
      if (step)       ph_q  <= ph_nxt;
    end
  end

  assign rate_tick_o = tick_q;
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int DAY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_hm_i,
  input  logic              wr_sec_i,
  input  logic              wr_day_i,
  input  logic [15:0]       wdata_i,
  output rtc_pkg::hms_t     tm_o,
  output logic [DAY_W-1:0]  day_o
);
  rtc_pkg::hms_t    tm_q;
  logic [DAY_W-1:0] day_q;
  logic             any_wr, c_sec, c_min, c_hr;

  assign any_wr = wr_hm_i | wr_sec_i | wr_day_i;
  assign c_sec  = tm_q.sc >= 6'd59;
  assign c_min  = c_sec && (tm_q.mn >= 6'd59);
  assign c_hr   = c_min && (tm_q.hr >= 5'd23);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_q  <= '0;
      day_q <= '0;
    end else if (any_wr) begin
      if (wr_sec_i) tm_q.sc <= wdata_i[5:0];
      if (wr_hm_i) begin
        tm_q.hr <= wdata_i[12:8];
        tm_q.mn <= wdata_i[5:0];
      end
      if (wr_day_i) day_q <= wdata_i[DAY_W-1:0];
    end else if (tick_i) begin
      tm_q.sc <= c_sec ? 6'd0 : tm_q.sc + 6'd1;
      if (c_sec) tm_q.mn <= c_min ? 6'd0 : tm_q.mn + 6'd1;
      if (c_min) tm_q.hr <= c_hr ? 5'd0 : tm_q.hr + 5'd1;
      if (c_hr)  day_q   <= day_q + DAY_W'(1);
    end
  end

  assign tm_o  = tm_q;
  assign day_o = day_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DAY_W    = 16,
  parameter int REF_HZ_0 = 32768,
  parameter int REF_HZ_1 = 32000,
  parameter int REF_HZ_2 = 38400,
  parameter int ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o
);
  import rtc_pkg::*;

  logic             wr, wr_hm, wr_sec, wr_day, wr_stat, tm_wr;
  logic             ctrl_en_q;
  logic [1:0]       fsel_q;
  hms_t             tm, alm_q;
  logic [DAY_W-1:0] day, aday_q;
  logic [15:0]      stat_q, ien_q, set_vec, clr_vec;
  logic [NRATE-1:0] rate_tick;
  logic             sec_tick, match, match_q, alarm_hit;
  logic [5:0]       ofs;

  assign ofs     = 6'(addr_i);
  assign wr      = sel_i & wr_i;
  assign wr_hm   = wr && ofs == OFS_HM;
  assign wr_sec  = wr && ofs == OFS_SEC;
  assign wr_day  = wr && ofs == OFS_DAY;
  assign wr_stat = wr && ofs == OFS_STAT;
  assign tm_wr   = wr_hm | wr_sec | wr_day;

  rtc_prescaler #(
    .REF_HZ_0(REF_HZ_0), .REF_HZ_1(REF_HZ_1), .REF_HZ_2(REF_HZ_2), .NRATE(NRATE)
  ) i_presc (
    .clk_i, .rst_ni, .en_i(ctrl_en_q), .ref_tick_i, .fsel_i(fsel_q),
    .rate_tick_o(rate_tick)
  );

  assign sec_tick = rate_tick[0] & ctrl_en_q;

  rtc_timekeeper #(.DAY_W(DAY_W)) i_time (
    .clk_i, .rst_ni, .tick_i(sec_tick), .wr_hm_i(wr_hm), .wr_sec_i(wr_sec),
    .wr_day_i(wr_day), .wdata_i, .tm_o(tm), .day_o(day)
  );

  assign match     = (tm == alm_q) && (day == aday_q);
  assign alarm_hit = ctrl_en_q && match && !match_q;

  always_comb begin
    set_vec = '0;
    set_vec[BIT_ALARM] = alarm_hit;
    set_vec[BIT_SEC]   = sec_tick;
    for (int j = 1; j < NRATE; j++) set_vec[BIT_RATE0+j-1] = rate_tick[j] & ctrl_en_q;
    clr_vec = wr_stat ? (wdata_i & STAT_MASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      fsel_q    <= '0;
      alm_q     <= '0;
      aday_q    <= '0;
      stat_q    <= '0;
      ien_q     <= '0;
      match_q   <= 1'b0;
    end else begin
      match_q <= match;
      stat_q  <= (stat_q & ~clr_vec) | set_vec;  // a same-edge event wins
      if (wr) begin
        unique case (ofs)
          OFS_CTRL: begin
            ctrl_en_q <= wdata_i[7];
            fsel_q    <= wdata_i[6:5];
          end
          OFS_AHM: begin
            alm_q.hr <= wdata_i[12:8];
            alm_q.mn <= wdata_i[5:0];
          end
          OFS_ASEC: alm_q.sc <= wdata_i[5:0];
          OFS_ADAY: aday_q   <= wdata_i[DAY_W-1:0];
          OFS_IEN:  ien_q    <= wdata_i & STAT_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (ofs)
      OFS_HM:   rdata_o = {3'b0, tm.hr, 2'b0, tm.mn};
      OFS_SEC:  rdata_o = {10'b0, tm.sc};
      OFS_AHM:  rdata_o = {3'b0, alm_q.hr, 2'b0, alm_q.mn};
      OFS_ASEC: rdata_o = {10'b0, alm_q.sc};
      OFS_CTRL: rdata_o = {8'b0, ctrl_en_q, fsel_q, 5'b0};
      OFS_STAT: rdata_o = stat_q;
      OFS_IEN:  rdata_o = ien_q;
      OFS_DAY:  rdata_o = 16'(day);
      OFS_ADAY: rdata_o = 16'(aday_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & ien_q);
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en,
  input logic        sec_tick,
  input logic        tm_wr,
  input logic        wr_stat,
  input logic        match,
  input logic [5:0]  sec,
  input logic [15:0] stat
);
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick && !tm_wr && sec < 6'd59) |=> sec == $past(sec) + 6'd1);  // R4

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick && !tm_wr && sec >= 6'd59) |=> sec == 6'd0);  // R4

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !tm_wr) |=> $stable(sec));  // R2

  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ($past(stat) & ~stat) == 16'h0);  // R9

  AST_ALARM_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[2]) |-> $past(match));  // R8
endmodule

bind rtc_core rtc_core_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(ctrl_en_q), .sec_tick(sec_tick),
  .tm_wr(tm_wr), .wr_stat(wr_stat), .match(match), .sec(tm.sc), .stat(stat_q)
);

// File: tb/test_rtc_core.sv
`timescale 1ns/1ps
module test_rtc_core;
  localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08, A_ASEC = 6'h0C,
                         A_CTRL = 6'h10, A_STAT = 6'h14, A_IEN = 6'h18,
                         A_DAY = 6'h20, A_ADAY = 6'h24;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1, sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_core #(.DAY_W(16), .REF_HZ_0(1024), .REF_HZ_1(1000), .REF_HZ_2(1200), .ADDR_W(6))
  i_rtc_core (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_sec_change(output int t);
    logic [15:0] prev;
    bus_rd(A_SEC, prev);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (rdata != prev) begin t = cyc; return; end
    end
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (irq) begin t = cyc; return; end
    end
  endtask

  task automatic set_time(input logic [15:0] d, input logic [15:0] hm, input logic [15:0] s);
    bus_wr(A_CTRL, 16'h0000);
    bus_wr(A_SEC, s);
    bus_wr(A_HM, hm);
    bus_wr(A_DAY, d);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    logic [5:0] regs[9] = '{A_HM, A_SEC, A_AHM, A_ASEC, A_CTRL, A_STAT, A_IEN, A_DAY, A_ADAY};
    foreach (regs[i]) begin
      bus_rd(regs[i], v);
      chk(v == 0, "R1", "register after reset", v, 0);
    end
    chk(irq == 0, "R1", "irq after reset", irq, 0);
    bus_rd(6'h1C, v); chk(v == 0, "R12", "unmapped 0x1C", v, 0);
    bus_rd(6'h28, v); chk(v == 0, "R12", "unmapped 0x28", v, 0);
  endtask

  task automatic t_ctrl;
    logic [15:0] v, a, b;
    bus_wr(A_CTRL, 16'h00C0);
    bus_rd(A_CTRL, v); chk(v == 16'h00C0, "R2", "control readback", v, 16'h00C0);
    bus_wr(A_CTRL, 16'h0000);
    bus_rd(A_SEC, a);
    repeat (1500) @(negedge clk);
    bus_rd(A_SEC, b); chk(a == b, "R2", "seconds frozen while off", b, a);
  endtask

  task automatic t_rate(input logic [1:0] fs, input int exp);
    int t1, t2;
    bus_wr(A_CTRL, 16'h0080 | (16'(fs) << 5));
    wait_sec_change(t1);
    wait_sec_change(t2);
    chk(t1 >= 0 && t2 - t1 == exp, "R3", $sformatf("second period sel %0d", fs), t2 - t1, exp);
    bus_wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_roll(input logic [15:0] d, input logic [15:0] hm,
                        input logic [15:0] ed, input logic [15:0] ehm, input string req);
    int t;
    logic [15:0] v;
    set_time(d, hm, 16'd59);
    bus_wr(A_CTRL, 16'h0080);
    wait_sec_change(t);
    bus_wr(A_CTRL, 16'h0000);
    bus_rd(A_SEC, v); chk(v == 0, req, "seconds after carry", v, 0);
    bus_rd(A_HM, v);  chk(v == ehm, req, "hour/minute after carry", v, ehm);
    bus_rd(A_DAY, v); chk(v == ed, req, "day after carry", v, ed);
  endtask

  task automatic t_layout;
    logic [15:0] v;
    bus_wr(A_HM, 16'h0C22);
    bus_rd(A_HM, v); chk(v == 16'h0C22, "R11", "hour/minute layout", v, 16'h0C22);
    bus_wr(A_AHM, 16'h1705);
    bus_rd(A_AHM, v); chk(v == 16'h1705, "R11", "alarm hour/minute layout", v, 16'h1705);
  endtask

  task automatic t_period(input int b, input int exp, input string req);
    int t1, t2;
    bus_wr(A_CTRL, 16'h0080);
    bus_wr(A_IEN, 16'(1) << b);
    bus_wr(A_STAT, 16'hFFFF);
    wait_irq(t1);
    bus_wr(A_STAT, 16'(1) << b);
    wait_irq(t2);
    chk(t1 >= 0 && t2 - t1 == exp, req, $sformatf("status bit %0d period", b), t2 - t1, exp);
    bus_wr(A_CTRL, 16'h0000);
    bus_wr(A_IEN, 16'h0000);
  endtask

  task automatic t_alarm;
    int t;
    logic [15:0] v;
    set_time(16'd3, 16'h0000, 16'd0);
    bus_wr(A_ADAY, 16'd3);
    bus_wr(A_AHM, 16'h0000);
    bus_wr(A_ASEC, 16'd2);
    bus_wr(A_STAT, 16'hFFFF);
    bus_wr(A_IEN, 16'h0004);
    bus_wr(A_CTRL, 16'h0080);
    wait_sec_change(t);
    repeat (2) @(negedge clk);
    bus_rd(A_STAT, v); chk(v[2] == 0, "R8", "alarm before match", v[2], 0);
    chk(irq == 0, "R10", "irq before match", irq, 0);
    wait_sec_change(t);
    repeat (2) @(negedge clk);
    bus_rd(A_STAT, v); chk(v[2] == 1, "R8", "alarm on match", v[2], 1);
    chk(irq == 1, "R10", "irq on enabled alarm", irq, 1);
    bus_wr(A_STAT, 16'h0000);
    bus_rd(A_STAT, v); chk(v[2] == 1, "R9", "writing 0 keeps bit", v[2], 1);
    bus_wr(A_IEN, 16'h0000);
    #1; chk(irq == 0, "R10", "irq with alarm masked", irq, 0);
    bus_wr(A_IEN, 16'h0004);
    bus_wr(A_STAT, 16'h0004);
    bus_rd(A_STAT, v); chk(v[2] == 0, "R9", "write 1 clears alarm", v[2], 0);
    repeat (100) @(negedge clk);
    bus_rd(A_STAT, v); chk(v[2] == 0, "R8", "no re-fire while matched", v[2], 0);
    bus_wr(A_CTRL, 16'h0000);
    bus_wr(A_IEN, 16'h0000);
  endtask

  task automatic t_collide;
    int ones = 0, zeros = 0;
    bus_wr(A_CTRL, 16'h0080);
    repeat (4) @(negedge clk);
    @(negedge clk); sel = 1; wr = 1; addr = A_STAT; wdata = 16'h8000;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (rdata[15]) ones++; else zeros++;
    end
    sel = 0; wr = 0;
    chk(ones > 0, "R9", "512 Hz set survives same-edge clear", ones, 1);
    chk(zeros > 0, "R9", "held clear removes 512 Hz bit", zeros, 1);
    bus_wr(A_CTRL, 16'h0000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_rate(2'b00, 1024);
    t_rate(2'b01, 1000);
    t_rate(2'b10, 1200);
    t_rate(2'b11, 1024);
    t_roll(16'd5, 16'h173B, 16'd6, 16'h0000, "R4");
    t_roll(16'd9, 16'h0A05, 16'd9, 16'h0A06, "R4");
    t_roll(16'hFFFF, 16'h173B, 16'd0, 16'h0000, "R5");
    t_layout();
    t_period(4, 1024, "R7");
    t_period(7, 512, "R6");
    t_period(8, 256, "R6");
    t_period(12, 16, "R6");
    t_alarm();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule